// File: doc/BRIEF.md
# Serial Path Overhead Insertion Port

This block is a bit-serial port through which logic outside the chip supplies path overhead bytes for an outgoing SONET/SDH payload. It generates a port clock from the system clock. It drives a frame strobe and a per-byte enable strobe toward the external logic, and it reads back an insert-request line and a serial data line. For every path overhead byte slot it assembles eight received bits into a byte. It also hands the mapper a flag that says whether the external value should replace the mapper's own.

The mapper side issues one slot request per overhead byte and marks the request that opens a payload frame (the J1 slot). The port then announces the byte one port-clock period ahead on a falling edge of the port clock. It samples the eight data bits, most significant bit first, on the next eight falling edges, and delivers the byte with a one-cycle valid pulse. The nine slots of a frame are numbered 0 (J1) through 8. The slot index advances on each request and wraps from 8 back to 0. A J1-marked request always forces index 0.

The whole design runs on the system clock. The rising and falling phases of the port clock are decoded as single-cycle enables.

Top module: `poh_serial_port`

## Requirements
- R1: The port clock `pclk_o` has a period of CLK_DIV system clock cycles (CLK_DIV at least 2) and is high for CLK_DIV/2 (rounded down) cycles of each period.
- R2: `frame_o` and `en_o` change value only in the system cycle that directly follows a falling edge of `pclk_o`. `ins_i` and `data_i` are sampled at those same falling edges.
- R3: For every accepted slot request, `en_o` rises on a falling edge of `pclk_o` and stays high for exactly one port-clock period. It is therefore high at the first rising edge after it rises and low at the following seven rising edges of the byte.
- R4: `frame_o` rises together with `en_o` only for slot 0 (J1). It stays high for exactly eight port-clock periods, covering all eight bits of that byte, and is low for all other slots.
- R5: The eight bits of a byte are sampled on the eight falling edges that follow the announcing edge, most significant bit first. The first bit sampled becomes bit 7 of `byte_o`.
- R6: After the eighth sample, `valid_o` is high for exactly one system cycle, with `byte_o` holding the assembled byte and `slot_o` holding the slot index 0..8.
- R7: `flag_o` (valid with `valid_o`) is 1 only if `ins_i` was sampled high on all eight bit samples of the byte. Otherwise it is 0.
- R8: Without a J1 marking, each accepted request takes the slot index after the previous one, and index 8 is followed by 0. A request with `slot_j1_i` high always takes index 0.
- R9: After reset, slot requests are ignored until the first request with `slot_j1_i` high. An ignored request produces no strobe and no valid pulse.
- R10: While `rst_n` is low at a clock edge, `pclk_o`, `frame_o`, `en_o` and `valid_o` are driven to 0 from the following cycle on, and any byte in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_req_i | input | 1 | One-cycle request from the mapper for the next overhead byte slot |
| slot_j1_i | input | 1 | Marks the request as the J1 slot that opens a payload frame |
| ins_i | input | 1 | Insert request from the external logic, sampled with each bit |
| data_i | input | 1 | Serial overhead data from the external logic, MSB first |
| pclk_o | output | 1 | Port clock toward the external logic |
| frame_o | output | 1 | Frame strobe, high for the eight bit periods of the J1 byte |
| en_o | output | 1 | Byte enable strobe, one port period ahead of each byte |
| byte_o | output | BYTE_BITS | Assembled overhead byte |
| flag_o | output | 1 | Use-external-value flag for `byte_o` |
| slot_o | output | 4 | Slot index (0 = J1 .. 8) of `byte_o` |
| valid_o | output | 1 | One-cycle pulse qualifying `byte_o`, `flag_o`, `slot_o` |

## Verification
The assertions assume that the mapper raises `slot_req_i` only while no byte is pending or being received. This means one byte in flight at a time, with the next request coming after the previous valid pulse. The bench always waits for the valid pulse, or for the end of an observation window, before it issues another request. The external side is modelled as the real external logic would behave: it changes `ins_i` and `data_i` one system cycle after a rising edge of `pclk_o`, so they are stable at the falling edge where the port samples them. Reset is applied only at system clock edges, through the bench's own drive of `rst_n`.

// File: rtl/poh_port_pkg.sv
package poh_port_pkg;

  // Number of overhead byte slots per payload frame; slot 0 is J1.
  localparam int POH_SLOTS = 9;
  localparam int SLOT_W    = 4;

  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PEND = 2'd1,
    SEQ_BITS = 2'd2
  } seq_state_e;

  // Slot index that follows s, wrapping after the last slot.
  function automatic slot_t slot_after(slot_t s);
    if (s == slot_t'(POH_SLOTS - 1)) return '0;
    return s + slot_t'(1);
  endfunction

endpackage

// File: rtl/poh_port_clkgen.sv
module poh_port_clkgen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic pclk_o,
  output logic fall_en_o
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int CNT_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_FALL = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] div_q;
  logic             pclk_q;
  logic             rise_en;
  logic             fall_en;

  // Phase events: the edge at which pclk goes high / low.
  assign rise_en = (div_q == CNT_LAST);
  assign fall_en = (div_q == CNT_FALL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      pclk_q <= 1'b0;
    end else begin
      div_q <= rise_en ? '0 : div_q + CNT_W'(1);
      if (rise_en)      pclk_q <= 1'b1;
      else if (fall_en) pclk_q <= 1'b0;
    end
  end

  assign pclk_o    = pclk_q;
  assign fall_en_o = fall_en;

  a_r1_rise_on_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pclk_q) |-> $past(rise_en));
  a_r1_fall_on_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pclk_q) |-> $past(fall_en));
  a_r1_div_range: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= CNT_LAST);

endmodule

// File: rtl/poh_port_sequencer.sv
module poh_port_sequencer
  import poh_port_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  fall_en_i,
  input  logic  slot_req_i,
  input  logic  slot_j1_i,
  output logic  en_o,
  output logic  frame_o,
  output logic  sample_en_o,
  output logic  first_bit_o,
  output logic  last_bit_o,
  output slot_t slot_o
);
  localparam int BIT_W = $clog2(BYTE_BITS + 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_BITS - 1);

  seq_state_e       state_q;
  logic [BIT_W-1:0] bit_q;
  logic             locked_q;
  slot_t            slot_q;
  logic             en_q;
  logic             frame_q;

  // Named internal events.
  logic accept;
  logic announce;
  logic sample_en;
  logic last_bit;

  assign accept    = (state_q == SEQ_IDLE) && slot_req_i && (locked_q || slot_j1_i);
  assign announce  = (state_q == SEQ_PEND) && fall_en_i;
  assign sample_en = (state_q == SEQ_BITS) && fall_en_i;
  assign last_bit  = (bit_q == BIT_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SEQ_IDLE;
      bit_q    <= '0;
      locked_q <= 1'b0;
      slot_q   <= '0;
      en_q     <= 1'b0;
      frame_q  <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (accept) begin
            state_q  <= SEQ_PEND;
            locked_q <= 1'b1;
            slot_q   <= slot_j1_i ? slot_t'(0) : slot_after(slot_q);
          end
        end
        SEQ_PEND: begin
          if (announce) begin
            state_q <= SEQ_BITS;
            bit_q   <= '0;
            en_q    <= 1'b1;
            frame_q <= (slot_q == slot_t'(0));
          end
        end
        SEQ_BITS: begin
          if (sample_en) begin
            en_q  <= 1'b0;
            bit_q <= bit_q + BIT_W'(1);
            if (last_bit) begin
              state_q <= SEQ_IDLE;
              frame_q <= 1'b0;
            end
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign en_o        = en_q;
  assign frame_o     = frame_q;
  assign sample_en_o = sample_en;
  assign first_bit_o = (bit_q == '0);
  assign last_bit_o  = last_bit;
  assign slot_o      = slot_q;

  // Input assumption: one byte in flight at a time.
  a_r8_req_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    slot_req_i |-> (state_q == SEQ_IDLE));
  a_r2_en_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_q) |-> $past(fall_en_i));
  a_r2_frame_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_q) |-> $past(fall_en_i));
  a_r3_en_one_period: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && fall_en_i) |=> !en_q);
  a_r4_frame_only_j1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_q |-> (slot_q == slot_t'(0)) && (state_q == SEQ_BITS));
  a_r4_frame_ends_last_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_q) |-> $past(sample_en && last_bit));
  a_r8_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q < slot_t'(POH_SLOTS));
  a_r9_lock_on_j1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_q) |-> (slot_q == slot_t'(0)));

endmodule

// File: rtl/poh_port_shifter.sv
module poh_port_shifter
  import poh_port_pkg::*;
#(
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sample_en_i,
  input  logic                 first_bit_i,
  input  logic                 last_bit_i,
  input  logic                 data_i,
  input  logic                 ins_i,
  input  slot_t                slot_i,
  output logic [BYTE_BITS-1:0] byte_o,
  output logic                 flag_o,
  output slot_t                slot_o,
  output logic                 valid_o
);
  typedef logic [BYTE_BITS-1:0] word_t;

  // Shift one bit in at the low end; earlier bits move toward the MSB.
  function automatic word_t push_bit(word_t acc, logic b);
    return {acc[BYTE_BITS-2:0], b};
  endfunction

  word_t sh_q;
  logic  all_ins_q;
  word_t byte_q;
  logic  flag_q;
  slot_t slot_q;
  logic  valid_q;

  // Named internal values for this sample.
  word_t sh_base;
  word_t sh_next;
  logic  ins_next;
  logic  byte_done;

  assign sh_base   = first_bit_i ? word_t'(0) : sh_q;
  assign sh_next   = push_bit(sh_base, data_i);
  assign ins_next  = ins_i & (first_bit_i | all_ins_q);
  assign byte_done = sample_en_i && last_bit_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q      <= '0;
      all_ins_q <= 1'b0;
      byte_q    <= '0;
      flag_q    <= 1'b0;
      slot_q    <= '0;
      valid_q   <= 1'b0;
    end else begin
      valid_q <= byte_done;
      if (sample_en_i) begin
        sh_q      <= sh_next;
        all_ins_q <= ins_next;
      end
      if (byte_done) begin
        byte_q <= sh_next;
        flag_q <= ins_next;
        slot_q <= slot_i;
      end
    end
  end

  assign byte_o  = byte_q;
  assign flag_o  = flag_q;
  assign slot_o  = slot_q;
  assign valid_o = valid_q;

  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
  a_r7_flag_needs_last_ins: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && flag_q) |-> $past(ins_i));
  a_r5_hold_between_samples: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_en_i) |-> $stable(sh_q));
  a_r6_valid_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(sample_en_i));

endmodule

// File: rtl/poh_serial_port.sv
module poh_serial_port
  import poh_port_pkg::*;
#(
  parameter int CLK_DIV   = 4,
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 slot_req_i,
  input  logic                 slot_j1_i,
  input  logic                 ins_i,
  input  logic                 data_i,
  output logic                 pclk_o,
  output logic                 frame_o,
  output logic                 en_o,
  output logic [BYTE_BITS-1:0] byte_o,
  output logic                 flag_o,
  output logic [SLOT_W-1:0]    slot_o,
  output logic                 valid_o
);
  logic  fall_en;
  logic  sample_en;
  logic  first_bit;
  logic  last_bit;
  slot_t cur_slot;

  poh_port_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .pclk_o    (pclk_o),
    .fall_en_o (fall_en)
  );

  poh_port_sequencer #(.BYTE_BITS(BYTE_BITS)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fall_en_i   (fall_en),
    .slot_req_i  (slot_req_i),
    .slot_j1_i   (slot_j1_i),
    .en_o        (en_o),
    .frame_o     (frame_o),
    .sample_en_o (sample_en),
    .first_bit_o (first_bit),
    .last_bit_o  (last_bit),
    .slot_o      (cur_slot)
  );

  poh_port_shifter #(.BYTE_BITS(BYTE_BITS)) u_shift (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_en_i (sample_en),
    .first_bit_i (first_bit),
    .last_bit_i  (last_bit),
    .data_i      (data_i),
    .ins_i       (ins_i),
    .slot_i      (cur_slot),
    .byte_o      (byte_o),
    .flag_o      (flag_o),
    .slot_o      (slot_o),
    .valid_o     (valid_o)
  );

  // Sampling happens only at a falling edge of the port clock.
  a_r2_sample_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> pclk_o);
  a_r10_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !en_o && !frame_o && !valid_o);

endmodule

// File: tb/poh_serial_port_test.sv
module poh_serial_port_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;
  localparam int NVEC       = 12;

  // {j1, insert pattern (first bit = MSB), data byte, expected slot}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1, 8'hFF, 8'hA5, 4'd0},
    {1'b0, 8'hFF, 8'h3C, 4'd1},
    {1'b0, 8'h7F, 8'hFF, 4'd2},
    {1'b0, 8'hFE, 8'h81, 4'd3},
    {1'b0, 8'h00, 8'h5A, 4'd4},
    {1'b0, 8'hFF, 8'h00, 4'd5},
    {1'b0, 8'hFF, 8'hFF, 4'd6},
    {1'b0, 8'hEF, 8'h12, 4'd7},
    {1'b0, 8'hFF, 8'hC3, 4'd8},
    {1'b0, 8'hFF, 8'h96, 4'd0},
    {1'b0, 8'hFF, 8'h11, 4'd1},
    {1'b1, 8'hFF, 8'h77, 4'd0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       slot_req_i = 1'b0;
  logic       slot_j1_i = 1'b0;
  logic       ins_i = 1'b0;
  logic       data_i = 1'b0;
  logic       pclk_o, frame_o, en_o, flag_o, valid_o;
  logic [7:0] byte_o;
  logic [3:0] slot_o;

  int  errors = 0;
  int  checks = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  poh_serial_port #(.CLK_DIV(DIV), .BYTE_BITS(8)) uut (
    .clk(clk), .rst_n(rst_n), .slot_req_i(slot_req_i), .slot_j1_i(slot_j1_i),
    .ins_i(ins_i), .data_i(data_i), .pclk_o(pclk_o), .frame_o(frame_o),
    .en_o(en_o), .byte_o(byte_o), .flag_o(flag_o), .slot_o(slot_o),
    .valid_o(valid_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Advance to the first system cycle after a rising edge of pclk_o.
  task automatic port_rise();
    logic prev;
    do begin
      prev = pclk_o;
      step();
    end while (!(pclk_o && !prev));
  endtask

  task automatic request(input logic j1);
    slot_req_i = 1'b1;
    slot_j1_i  = j1;
    step();
    slot_req_i = 1'b0;
    slot_j1_i  = 1'b0;
  endtask

  task automatic run_byte(input logic j1, input logic [7:0] insp,
                          input logic [7:0] dat, input logic [3:0] exp_slot);
    bit         found = 1'b0;
    logic       exp_frame;
    int         pulses = 0;
    logic [7:0] got_byte = '0;
    logic       got_flag = 1'b0;
    logic [3:0] got_slot = '0;
    exp_frame = (exp_slot == 4'd0);
    request(j1);
    for (int k = 0; k < 4 && !found; k++) begin
      port_rise();
      if (en_o) found = 1'b1;
    end
    chk(found, "R3 enable announce", int'(en_o), 1);
    chk(frame_o == exp_frame, "R4 frame at announce", int'(frame_o), int'(exp_frame));
    for (int i = 0; i < 8; i++) begin
      if (i > 0) begin
        port_rise();
        chk(en_o == 1'b0, "R3 enable one period", int'(en_o), 0);
        chk(frame_o == exp_frame, "R4 frame width", int'(frame_o), int'(exp_frame));
      end
      ins_i  = insp[7-i];
      data_i = dat[7-i];
    end
    for (int c = 0; c < 4 * DIV; c++) begin
      step();
      if (valid_o) begin
        pulses++;
        got_byte = byte_o;
        got_flag = flag_o;
        got_slot = slot_o;
      end
    end
    ins_i  = 1'b0;
    data_i = 1'b0;
    chk(pulses == 1, "R6 single valid pulse", pulses, 1);
    chk(got_byte == dat, "R5 byte msb first", int'(got_byte), int'(dat));
    chk(got_flag == (&insp), "R7 insert flag", int'(got_flag), int'(&insp));
    chk(got_slot == exp_slot, "R8 slot index", int'(got_slot), int'(exp_slot));
    chk(frame_o == 1'b0, "R4 frame low after byte", int'(frame_o), 0);
  endtask

  task automatic expect_ignored(input string req);
    bit seen = 1'b0;
    request(1'b0);
    for (int c = 0; c < 12 * DIV; c++) begin
      step();
      if (en_o || frame_o || valid_o) seen = 1'b1;
    end
    chk(!seen, req, int'(seen), 0);
  endtask

  initial begin
    int period;
    int highs;
    logic prev;
    rst_n = 1'b0;
    repeat (5) step();
    // R10: reset state
    chk({pclk_o, frame_o, en_o, valid_o} == 4'b0, "R10 reset outputs",
        int'({pclk_o, frame_o, en_o, valid_o}), 0);
    rst_n = 1'b1;

    // R1: port clock period and high time
    port_rise();
    period = 0;
    highs  = 1;
    forever begin
      prev = pclk_o;
      step();
      period++;
      if (pclk_o && !prev) break;
      if (pclk_o) highs++;
    end
    chk(period == DIV, "R1 port clock period", period, DIV);
    chk(highs == DIV / 2, "R1 port clock high time", highs, DIV / 2);

    // R9: no strobe before the first J1 request
    expect_ignored("R9 request before J1 ignored");

    // Main table: R3..R8 across a frame, wrap and resync
    for (int v = 0; v < NVEC; v++) begin
      run_byte(VEC[v][20], VEC[v][19:12], VEC[v][11:4], VEC[v][3:0]);
    end

    // R10: reset in the middle of a byte drops it
    request(1'b1);
    begin
      bit found = 1'b0;
      for (int k = 0; k < 4 && !found; k++) begin
        port_rise();
        if (en_o) found = 1'b1;
      end
      chk(found && frame_o, "R4 frame before reset", int'(frame_o), 1);
    end
    ins_i  = 1'b1;
    data_i = 1'b1;
    rst_n  = 1'b0;
    step();
    chk({pclk_o, frame_o, en_o, valid_o} == 4'b0, "R10 reset mid-byte",
        int'({pclk_o, frame_o, en_o, valid_o}), 0);
    step();
    rst_n  = 1'b1;
    ins_i  = 1'b0;
    data_i = 1'b0;

    // R9: after reset the lock is gone again
    expect_ignored("R9 request ignored after reset");
    run_byte(1'b1, 8'hFF, 8'h3C, 4'd0);
    run_byte(1'b0, 8'hBF, 8'hE7, 4'd1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule